// File: doc/BRIEF.md
# Write-Enable Latch and Protection Status Unit

This unit sits beside the serial command engine of a small serial EEPROM. The engine decodes the wire traffic and reports events to the unit as one-cycle strobes: an instruction byte that has just been completed, each further serial bit after that byte, a chip-select rising edge, and a request to commit a finished write sequence. A commit request carries either a target array address or a new block-protect setting. The unit holds the write-enable latch, the two block-protect bits and the write-in-progress flag, and it times the internal write cycle with a counter of system clocks.

It tells the array controller when an array write may begin (`writePermit`) and reports `busy` while a self-timed cycle runs. It also provides the 8-bit status byte that the engine shifts out for a status read. An active-low hardware protect pin clears the latch at any time and blocks every commit, but it never cuts short a cycle that is already running.

Top module: `wel_guard`

## Requirements
- R1: After reset, `statusByte` is 0, `busy` is 0 and `writePermit` is 0.
- R2: An instruction strobe with `opKind` = 1 (set latch) sets the latch (status bit 1) only if the next event is a `csRise` strobe. A `bitStrobe` or another instruction strobe between the two cancels the pending set, and the latch stays clear.
- R3: An instruction strobe with `opKind` = 2 (clear latch) clears the latch. `opKind` values 0 and 3 leave it unchanged.
- R4: While `wpN` is 0, the latch reads 0 from the next cycle on. Commit requests are ignored: `busy` stays 0 and the protect bits keep their value.
- R5: If `wpN` falls while a write cycle runs, the cycle still lasts its full length.
- R6: An accepted commit raises `busy` (status bit 0) for exactly CYCLE_LEN clock cycles. The latch stays set during the cycle and is cleared in the same cycle that `busy` falls.
- R7: The status byte layout is bit 0 busy, bit 1 latch, bit 2 protect bit 0, bit 3 protect bit 1. Bits 7..4 always read 0.
- R8: An array commit is accepted only when the latch is set, `busy` is 0 and `wpN` is 1. The protect code then decides: code 0 protects no address, code 1 protects addresses whose two top bits are 11, code 2 protects addresses whose top bit is 1, and code 3 protects all addresses. A commit to an unprotected address raises `writePermit` for one cycle, in the first cycle of `busy`. A commit to a protected address is dropped: `busy` stays 0 and the latch is cleared.
- R9: A commit request, for the array or the status register, while the latch is clear has no effect.
- R10: While `busy` is 1, instruction strobes, `csRise` and further commit requests do not change the latch or the protect bits, and they start no new cycle.
- R11: An accepted status commit loads `newBp` into the protect bits in the cycle `busy` rises and runs a full write cycle, whatever the current protect code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdDone | input | 1 | Strobe: an instruction byte has just been completed |
| opKind | input | 2 | Decoded instruction: 1 set latch, 2 clear latch, other values neither |
| bitStrobe | input | 1 | Strobe: one more serial bit was clocked after the instruction byte |
| csRise | input | 1 | Strobe: chip select went high |
| commitArray | input | 1 | Strobe: a complete array write sequence ended with chip select high |
| commitStatus | input | 1 | Strobe: a complete status write sequence ended with chip select high |
| targetAddr | input | ADDR_W | Array address of the commit |
| newBp | input | 2 | Protect code carried by a status commit |
| wpN | input | 1 | Hardware write protect, active low |
| writePermit | output | 1 | One-cycle pulse: the array write may proceed |
| busy | output | 1 | A self-timed write cycle is running |
| statusByte | output | 8 | Status byte for a status read |

## Verification
The hardest situation to reach from the ports is the protect pin falling in the middle of a running cycle. The bench must first arm the latch, commit an unprotected write, and only then drop `wpN` several cycles into the timed window. It then checks that `busy` stays high for the full length and that the latch still reads 0 after the cycle ends. The address-range rule is covered by a sweep: each of the four protect codes is installed through a status commit, and then every array address is committed in turn. For each one, the expected permit is computed from the address value.

// File: rtl/wel_guard_pkg.sv
package wel_guard_pkg;

  localparam logic [1:0] OP_SET_LATCH = 2'd1;
  localparam logic [1:0] OP_CLR_LATCH = 2'd2;

  typedef struct packed {
    logic       startCycle;
    logic       arrayWrite;
    logic       loadBp;
    logic [1:0] bpNext;
  } ctrlStrobes_t;

endpackage

// File: rtl/wel_guard_dp.sv
module wel_guard_dp
  import wel_guard_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int CYCLE_LEN = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [ADDR_W-1:0]  targetAddr,
  output logic               wip,
  output logic               cycleDone,
  output logic               addrLocked,
  output logic [1:0]         bp,
  output logic               permit
);

  localparam int CNT_W = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYCLE_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       topBits;

  assign topBits = targetAddr[ADDR_W-1 -: 2];

  // Protection window: upper quarter, upper half or whole array.
  always_comb begin
    unique case (bp)
      2'd0:    addrLocked = 1'b0;
      2'd1:    addrLocked = (topBits == 2'b11);
      2'd2:    addrLocked = topBits[1];
      default: addrLocked = 1'b1;
    endcase
  end

  assign cycleDone = wip && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bp     <= 2'd0;
      wip    <= 1'b0;
      cnt    <= '0;
      permit <= 1'b0;
    end else begin
      permit <= strobes.startCycle && strobes.arrayWrite;
      if (strobes.loadBp) bp <= strobes.bpNext;
      if (strobes.startCycle) begin
        wip <= 1'b1;
        cnt <= CNT_LOAD;
      end else if (wip) begin
        if (cnt == '0) wip <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/wel_guard_ctrl.sv
module wel_guard_ctrl
  import wel_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdDone,
  input  logic [1:0]   opKind,
  input  logic         bitStrobe,
  input  logic         csRise,
  input  logic         commitArray,
  input  logic         commitStatus,
  input  logic [1:0]   newBp,
  input  logic         wpN,
  input  logic         wip,
  input  logic         cycleDone,
  input  logic         addrLocked,
  output ctrlStrobes_t strobes,
  output logic         wel
);

  logic setPending;
  logic gateOpen;
  logic acceptArr;
  logic dropArr;
  logic acceptSts;

  assign gateOpen  = wel && !wip && wpN;
  assign acceptArr = gateOpen && commitArray && !addrLocked;
  assign dropArr   = gateOpen && commitArray && addrLocked;
  assign acceptSts = gateOpen && commitStatus && !commitArray;

  always_comb begin
    strobes.startCycle = acceptArr || acceptSts;
    strobes.arrayWrite = acceptArr;
    strobes.loadBp     = acceptSts;
    strobes.bpNext     = newBp;
  end

  // A set request survives only until the very next serial event.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setPending <= 1'b0;
    end else if (wip) begin
      setPending <= 1'b0;
    end else if (cmdDone) begin
      setPending <= (opKind == OP_SET_LATCH);
    end else if (bitStrobe || csRise) begin
      setPending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0;
    end else if (!wpN || cycleDone || dropArr) begin
      wel <= 1'b0;
    end else if (!wip) begin
      if (cmdDone && opKind == OP_CLR_LATCH) wel <= 1'b0;
      else if (csRise && setPending && !cmdDone && !bitStrobe) wel <= 1'b1;
    end
  end

endmodule

// File: rtl/wel_guard.sv
module wel_guard
  import wel_guard_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int CYCLE_LEN = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdDone,
  input  logic [1:0]        opKind,
  input  logic              bitStrobe,
  input  logic              csRise,
  input  logic              commitArray,
  input  logic              commitStatus,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [1:0]        newBp,
  input  logic              wpN,
  output logic              writePermit,
  output logic              busy,
  output logic [7:0]        statusByte
);

  ctrlStrobes_t strobes;
  logic         wip;
  logic         cycleDone;
  logic         addrLocked;
  logic [1:0]   bp;
  logic         wel;

  wel_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdDone(cmdDone), .opKind(opKind),
    .bitStrobe(bitStrobe), .csRise(csRise), .commitArray(commitArray),
    .commitStatus(commitStatus), .newBp(newBp), .wpN(wpN), .wip(wip),
    .cycleDone(cycleDone), .addrLocked(addrLocked), .strobes(strobes),
    .wel(wel)
  );

  wel_guard_dp #(.ADDR_W(ADDR_W), .CYCLE_LEN(CYCLE_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .targetAddr(targetAddr),
    .wip(wip), .cycleDone(cycleDone), .addrLocked(addrLocked), .bp(bp),
    .permit(writePermit)
  );

  assign busy       = wip;
  assign statusByte = {4'b0000, bp, wel, wip};

endmodule

// File: rtl/wel_guard_sva.sv
module wel_guard_sva (
  input logic       clk,
  input logic       rstN,
  input logic       wpN,
  input logic       writePermit,
  input logic       busy,
  input logic [7:0] statusByte
);

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7:4] == 4'b0000);

  p_wp_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    !wpN |=> !statusByte[1]);

  p_permit_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    writePermit |-> busy);

  p_start_needs_latch_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(statusByte[1]) && $past(wpN)));

  p_end_clears_latch_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !statusByte[1]);

  p_bp_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(statusByte[3:2]));

  p_latch_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && wpN && $past(wpN)) |-> statusByte[1]);

endmodule

bind wel_guard wel_guard_sva u_sva (
  .clk(clk), .rstN(rstN), .wpN(wpN), .writePermit(writePermit),
  .busy(busy), .statusByte(statusByte)
);

// File: tb/tb_wel_guard.sv
`timescale 1ns/1ps
module tb_wel_guard;

  localparam int ADDR_W    = 9;
  localparam int CYCLE_LEN = 20;
  localparam int DEPTH     = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdDone = 1'b0;
  logic [1:0]        opKind = 2'd0;
  logic              bitStrobe = 1'b0;
  logic              csRise = 1'b0;
  logic              commitArray = 1'b0;
  logic              commitStatus = 1'b0;
  logic [ADDR_W-1:0] targetAddr = '0;
  logic [1:0]        newBp = 2'd0;
  logic              wpN = 1'b1;
  logic              writePermit;
  logic              busy;
  logic [7:0]        statusByte;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  wel_guard #(.ADDR_W(ADDR_W), .CYCLE_LEN(CYCLE_LEN)) dut (
    .clk(clk), .rstN(rstN), .cmdDone(cmdDone), .opKind(opKind),
    .bitStrobe(bitStrobe), .csRise(csRise), .commitArray(commitArray),
    .commitStatus(commitStatus), .targetAddr(targetAddr), .newBp(newBp),
    .wpN(wpN), .writePermit(writePermit), .busy(busy), .statusByte(statusByte)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] k);
    @(negedge clk); cmdDone = 1'b1; opKind = k;
    @(negedge clk); cmdDone = 1'b0; opKind = 2'd0;
  endtask

  task automatic csUp();
    @(negedge clk); csRise = 1'b1;
    @(negedge clk); csRise = 1'b0;
  endtask

  task automatic oneBit();
    @(negedge clk); bitStrobe = 1'b1;
    @(negedge clk); bitStrobe = 1'b0;
  endtask

  task automatic arm();
    cmd(2'd1); csUp();
  endtask

  task automatic commitArr(input int a);
    @(negedge clk); commitArray = 1'b1; targetAddr = ADDR_W'(a);
    @(negedge clk); commitArray = 1'b0;
  endtask

  task automatic commitSts(input logic [1:0] v);
    @(negedge clk); commitStatus = 1'b1; newBp = v;
    @(negedge clk); commitStatus = 1'b0;
  endtask

  // Called at the negedge after the start edge; returns the busy length.
  task automatic busyLen(output int len);
    len = 0;
    while (busy && len < 4 * CYCLE_LEN) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic setBp(input logic [1:0] v);
    int len;
    arm(); commitSts(v);
    chk(statusByte == {4'b0, v, 2'b11}, "R11 status during wrsr", statusByte, {4'b0, v, 2'b11});
    busyLen(len);
    chk(statusByte == {4'b0, v, 2'b00}, "R11 bp after wrsr", statusByte, {4'b0, v, 2'b00});
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin : stim
    int len;
    repeat (3) @(negedge clk);
    chk(statusByte == 8'h00 && !busy && !writePermit, "R1 reset state", statusByte, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: clean set, then sets spoiled by extra bits or instructions
    arm();
    chk(statusByte == 8'h02, "R2 set latch on clean cs rise", statusByte, 2);
    cmd(2'd2);
    chk(statusByte == 8'h00, "R3 clear latch", statusByte, 0);
    cmd(2'd1); oneBit(); csUp();
    chk(statusByte == 8'h00, "R2 extra bit cancels set", statusByte, 0);
    cmd(2'd1); cmd(2'd0); csUp();
    chk(statusByte == 8'h00, "R2 other instruction cancels set", statusByte, 0);
    arm(); cmd(2'd0); cmd(2'd3);
    chk(statusByte == 8'h02, "R3 kinds 0 and 3 keep latch", statusByte, 2);

    // R4: protect pin clears and blocks
    @(negedge clk); wpN = 1'b0;
    @(negedge clk);
    chk(statusByte == 8'h00, "R4 wp clears latch", statusByte, 0);
    cmd(2'd1); csUp();
    chk(statusByte == 8'h00, "R4 latch cannot set under wp", statusByte, 0);
    commitSts(2'd3); commitArr(0);
    chk(!busy && statusByte == 8'h00, "R4 commits ignored under wp", statusByte, 0);
    @(negedge clk); wpN = 1'b1;

    // R9: commits without latch
    commitArr(5); commitSts(2'd2);
    chk(!busy && !writePermit && statusByte == 8'h00, "R9 no latch no effect", statusByte, 0);

    // R6/R8: normal write, length and auto clear
    arm(); commitArr(17);
    chk(writePermit == 1'b1, "R8 permit pulse first busy cycle", writePermit, 1);
    chk(statusByte == 8'h03, "R7 layout busy and latch", statusByte, 3);
    @(negedge clk);
    chk(writePermit == 1'b0, "R8 permit one cycle", writePermit, 0);
    // R10: ignored while busy
    cmd(2'd2);
    chk(statusByte == 8'h03, "R10 clear ignored while busy", statusByte, 3);
    commitArr(3); commitSts(2'd1);
    chk(!writePermit && statusByte == 8'h03, "R10 commits ignored while busy", statusByte, 3);
    busyLen(len);
    chk(len == CYCLE_LEN - 7, "R6 busy remaining length", len, CYCLE_LEN - 7);
    chk(statusByte == 8'h00, "R6 latch cleared at end", statusByte, 0);

    arm(); commitArr(1);
    busyLen(len);
    chk(len == CYCLE_LEN, "R6 busy full length", len, CYCLE_LEN);

    // R5: protect pin falls mid-cycle
    arm(); commitArr(2);
    len = 1;
    repeat (3) begin @(negedge clk); len++; end
    wpN = 1'b0;
    while (busy && len < 4 * CYCLE_LEN) begin @(negedge clk); len++; end
    chk(len == CYCLE_LEN + 1, "R5 cycle completes under wp", len - 1, CYCLE_LEN);
    chk(statusByte == 8'h00, "R5 latch clear after cycle", statusByte, 0);
    @(negedge clk); wpN = 1'b1;

    // R8/R11: protect-code sweep over every address
    for (int b = 0; b < 4; b++) begin
      setBp(2'(b));
      for (int a = 0; a < DEPTH; a++) begin
        bit locked;
        locked = (b == 3) || (b == 2 && a >= DEPTH / 2) || (b == 1 && a >= 3 * DEPTH / 4);
        arm(); commitArr(a);
        chk(writePermit == !locked && busy == !locked, "R8 range check permit",
            writePermit, int'(!locked));
        chk(statusByte[1] == !locked, "R8 latch after commit", statusByte[1], int'(!locked));
        if (!locked) busyLen(len);
      end
    end
    chk(statusByte == 8'h0C, "R7 layout protect bits", statusByte, 12);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule